// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs one bus machine cycle at a time on a bus whose low address lines also carry data. A client presents a request made of a three-bit cycle kind, a 20-bit address and write data. The block then steps through the states T1, T2, T3, any wait states and T4. In each state it drives the address latch strobe, the memory/IO select, the read and write strobes, the data-buffer enable, the data direction and a three-bit status code. Wait states are added while the READY input is low. The shared lines are modelled as an output value, an output enable and a separate input value.

The cycle kind is the same number as the status code it produces:

| Code | Cycle kind |
|------|------------|
| 0 | interrupt acknowledge |
| 1 | I/O read |
| 2 | I/O write |
| 3 | halt |
| 4 | code fetch |
| 5 | memory read |
| 6 | memory write |

Code 7 is the passive status. For receive kinds the block returns the word it sampled from the bus, and it flags the end of every cycle with a one-cycle done pulse. The client holds a request steady from the moment it raises `req_valid` until `req_accept` is seen. If a new request is already present when T4 begins, the status lines show it during T4, and its T1 follows directly.

Top module: `mux_bus_seq`

## Requirements
- R1: With no request pending the block idles. In idle, `ale`=0, `ad_oe`=0, `rd_n`=`wr_n`=`den_n`=1, `m_io`=0, `dt_r`=0, `done`=0, `req_accept`=0 and `sts`=3'b111.
- R2: In T1, `ale`=1 and `ad_oe`=1, `ad_o` carries address bits 15:0 and `a_hi_o` carries bits 19:16. For kinds with bit 2 clear (I/O, acknowledge, halt), `a_hi_o` is 0 and `m_io`=0. For kinds with bit 2 set (memory and code), `m_io`=1 from T1 to T4.
- R3: A cycle with READY high at the end of T3 takes exactly four clocks: T1, T2, T3, T4. `req_accept` is high only in T1 and `done` is high only in T4.
- R4: `rd_n` is low in T2, T3 and every wait state for kinds 1, 4 and 5. `wr_n` is low in the same states for kinds 2 and 6. Kinds 0 and 3 assert neither, and both strobes are high in T1 and T4.
- R5: `dt_r` is 1 from T1 to T4 for kinds 2 and 6 and 0 for every other kind. `den_n` is low from T2 to T4 for every kind except 3, and high in T1.
- R6: For write kinds, `ad_oe`=1 and `ad_o` carries the write data from T2 to T4. For other kinds, `ad_oe`=0 after T1.
- R7: READY low at the end of T3, or at the end of a wait state, adds one more wait state. The first T3 or wait state that ends with READY high is followed by T4.
- R8: `sts` shows the cycle kind in T1 and T2 and shows 3'b111 in T3 and in every wait state.
- R9: If `req_valid` is high at the edge that enters T4, `sts` shows the new request's kind during T4 and the next clock is that request's T1. Otherwise `sts` is 3'b111 in T4.
- R10: For kinds 0, 1, 4 and 5, `rdata` takes the value on `ad_i` at the clock edge that ends the last T3 or wait state. It holds that value afterwards, whatever `ad_i` does later.
- R11: READY has no effect in idle, T1 or T2. Holding it low there neither adds wait states nor changes any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | a cycle request is present |
| req_kind | input | 3 | cycle kind, the same encoding as the status code |
| req_addr | input | 20 | cycle address |
| req_wdata | input | 16 | write data |
| req_accept | output | 1 | high during T1 of the accepted request |
| ready | input | 1 | high when the addressed target can finish the cycle |
| ad_i | input | 16 | value read from the shared address/data lines |
| ad_o | output | 16 | value driven on the shared address/data lines |
| ad_oe | output | 1 | enables the drive of `ad_o` |
| a_hi_o | output | 4 | upper address bits, valid in T1 |
| ale | output | 1 | address latch strobe |
| m_io | output | 1 | 1 for memory cycles, 0 for I/O cycles |
| dt_r | output | 1 | data direction: 1 transmit, 0 receive |
| rd_n | output | 1 | read strobe, active low |
| wr_n | output | 1 | write strobe, active low |
| den_n | output | 1 | data buffer enable, active low |
| sts | output | 3 | cycle status code |
| done | output | 1 | high for one clock in T4 |
| rdata | output | 16 | word sampled at the end of a receive cycle |

## Verification
The hardest situation to reach from the ports is the status preview in T4. It needs the next request to arrive in exactly the last T3 or wait state, after the wait count has been chosen. The bench gets there by scheduling that request inside the wait loop, at the same falling edge where it raises READY. It then checks `sts` in T4 and confirms that the next T1 follows without an idle state.

Read-data timing is checked with a bus value that is valid only around the sampling edge. The value is wrong before that edge and inverted after it, so an edge one clock early or late returns a wrong word. Every kind is swept against zero to three wait states, with READY held low through T1 and T2.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_TW   = 3'd4,
    PH_T4   = 3'd5
  } phase_e;

  localparam logic [2:0] KIND_ACK    = 3'b000;
  localparam logic [2:0] KIND_IORD   = 3'b001;
  localparam logic [2:0] KIND_IOWR   = 3'b010;
  localparam logic [2:0] KIND_HALT   = 3'b011;
  localparam logic [2:0] KIND_CODE   = 3'b100;
  localparam logic [2:0] KIND_MEMRD  = 3'b101;
  localparam logic [2:0] KIND_MEMWR  = 3'b110;
  localparam logic [2:0] STS_PASSIVE = 3'b111;

  function automatic logic kind_writes(input logic [2:0] k);
    return (k == KIND_IOWR) || (k == KIND_MEMWR);
  endfunction

  function automatic logic kind_rd_strobe(input logic [2:0] k);
    return (k == KIND_IORD) || (k == KIND_CODE) || (k == KIND_MEMRD);
  endfunction

  function automatic logic kind_receives(input logic [2:0] k);
    return kind_rd_strobe(k) || (k == KIND_ACK);
  endfunction

  function automatic logic kind_is_mem(input logic [2:0] k);
    return k[2];
  endfunction

  function automatic logic kind_is_halt(input logic [2:0] k);
    return k == KIND_HALT;
  endfunction

endpackage

// File: rtl/mbs_rst_sync.sv
module mbs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = sh_q[STAGES-1];
endmodule

// File: rtl/mbs_phase_fsm.sv
module mbs_phase_fsm
  import mbs_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  input  logic   ready,
  output phase_e phase_q,
  output phase_e phase_n
);

  always_comb begin
    phase_n = phase_q;
    case (phase_q)
      PH_IDLE: if (req_valid) phase_n = PH_T1;
      PH_T1:   phase_n = PH_T2;
      PH_T2:   phase_n = PH_T3;
      PH_T3:   phase_n = ready ? PH_T4 : PH_TW;
      PH_TW:   phase_n = ready ? PH_T4 : PH_TW;
      PH_T4:   phase_n = req_valid ? PH_T1 : PH_IDLE;
      default: phase_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_n;
  end

  // R3: T1 is always followed by T2
  a_r3_t1_then_t2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_T1) |=> (phase_q == PH_T2));

  // R7: a low READY late in the cycle adds a wait state
  a_r7_wait_insert: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_T3 || phase_q == PH_TW) && !ready) |=> (phase_q == PH_TW));

  // R7: a high READY late in the cycle moves to T4
  a_r7_wait_exit: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_T3 || phase_q == PH_TW) && ready) |=> (phase_q == PH_T4));

endmodule

// File: rtl/mbs_req_hold.sv
module mbs_req_hold
  import mbs_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_e        phase_q,
  input  phase_e        phase_n,
  input  logic          ready,
  input  logic [2:0]    req_kind,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] ad_i,
  output logic [2:0]    cur_kind,
  output logic [DW-1:0] cur_wdata,
  output logic [DW-1:0] rdata
);
  logic load_en;
  logic cap_en;

  assign load_en = (phase_n == PH_T1);
  assign cap_en  = (phase_q == PH_T3 || phase_q == PH_TW) && ready
                   && kind_receives(cur_kind);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_kind  <= STS_PASSIVE;
      cur_wdata <= '0;
    end else if (load_en) begin
      cur_kind  <= req_kind;
      cur_wdata <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (cap_en) rdata <= ad_i;
  end

  // R10: the sampled word stays put through T4 and after
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_T4) |=> $stable(rdata));

endmodule

// File: rtl/mbs_pin_drive.sv
module mbs_pin_drive
  import mbs_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16,
  localparam int HW = AW - DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_e        phase_q,
  input  phase_e        phase_n,
  input  logic          req_valid,
  input  logic [2:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [2:0]    cur_kind,
  input  logic [DW-1:0] cur_wdata,
  output logic          ale_q,
  output logic          ad_oe_q,
  output logic [DW-1:0] ad_q,
  output logic [HW-1:0] a_hi_q,
  output logic          m_io_q,
  output logic          dt_r_q,
  output logic          rd_n_q,
  output logic          wr_n_q,
  output logic          den_n_q,
  output logic [2:0]    sts_q,
  output logic          done_q,
  output logic          acc_q
);
  logic [2:0]    k_n;
  logic          in_t1, in_data, in_strobe, in_cycle, wr_k;
  logic          ale_d, oe_d, mio_d, dtr_d, rdn_d, wrn_d, denn_d, done_d, acc_d;
  logic [DW-1:0] ad_d;
  logic [HW-1:0] ahi_d;
  logic [2:0]    sts_d;

  always_comb begin
    in_t1     = (phase_n == PH_T1);
    in_strobe = (phase_n == PH_T2) || (phase_n == PH_T3) || (phase_n == PH_TW);
    in_data   = in_strobe || (phase_n == PH_T4);
    in_cycle  = (phase_n != PH_IDLE);
    k_n       = in_t1 ? req_kind : cur_kind;
    wr_k      = kind_writes(k_n);

    ale_d  = in_t1;
    oe_d   = in_t1 || (in_data && wr_k);
    if (in_t1)             ad_d = req_addr[DW-1:0];
    else if (in_data && wr_k) ad_d = cur_wdata;
    else                   ad_d = '0;
    ahi_d  = (in_t1 && kind_is_mem(k_n)) ? req_addr[AW-1:DW] : '0;
    mio_d  = in_cycle && kind_is_mem(k_n);
    dtr_d  = in_cycle && wr_k;
    rdn_d  = !(in_strobe && kind_rd_strobe(k_n));
    wrn_d  = !(in_strobe && wr_k);
    denn_d = !(in_data && !kind_is_halt(k_n));
    done_d = (phase_n == PH_T4);
    acc_d  = in_t1;

    case (phase_n)
      PH_T1:   sts_d = req_kind;
      PH_T2:   sts_d = cur_kind;
      PH_T4:   sts_d = req_valid ? req_kind : STS_PASSIVE;
      default: sts_d = STS_PASSIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_q   <= 1'b0;
      ad_oe_q <= 1'b0;
      ad_q    <= '0;
      a_hi_q  <= '0;
      m_io_q  <= 1'b0;
      dt_r_q  <= 1'b0;
      rd_n_q  <= 1'b1;
      wr_n_q  <= 1'b1;
      den_n_q <= 1'b1;
      sts_q   <= STS_PASSIVE;
      done_q  <= 1'b0;
      acc_q   <= 1'b0;
    end else begin
      ale_q   <= ale_d;
      ad_oe_q <= oe_d;
      ad_q    <= ad_d;
      a_hi_q  <= ahi_d;
      m_io_q  <= mio_d;
      dt_r_q  <= dtr_d;
      rd_n_q  <= rdn_d;
      wr_n_q  <= wrn_d;
      den_n_q <= denn_d;
      sts_q   <= sts_d;
      done_q  <= done_d;
      acc_q   <= acc_d;
    end
  end

  // R4: read and write strobes never overlap
  a_r4_no_dual_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n_q && !wr_n_q));

  // R8: status is passive in T3 and in wait states
  a_r8_passive_late: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_T3 || phase_q == PH_TW) |-> (sts_q == STS_PASSIVE));

  // R1: an idle bus is quiet
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE) |-> (!ale_q && !ad_oe_q && rd_n_q && wr_n_q && den_n_q));

  // R2: the latch strobe lasts one clock
  a_r2_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
    ale_q |=> !ale_q);

  // R3: done lasts one clock
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mbs_pkg::*;
#(
  parameter int AW          = 20,
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2,
  localparam int HW         = AW - DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_accept,
  input  logic          ready,
  input  logic [DW-1:0] ad_i,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe,
  output logic [HW-1:0] a_hi_o,
  output logic          ale,
  output logic          m_io,
  output logic          dt_r,
  output logic          rd_n,
  output logic          wr_n,
  output logic          den_n,
  output logic [2:0]    sts,
  output logic          done,
  output logic [DW-1:0] rdata
);
  logic          srst_n;
  phase_e        phase_q, phase_n;
  logic [2:0]    cur_kind;
  logic [DW-1:0] cur_wdata;

  mbs_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n(srst_n)
  );

  mbs_phase_fsm u_fsm (
    .clk(clk), .rst_n(srst_n), .req_valid(req_valid), .ready(ready),
    .phase_q(phase_q), .phase_n(phase_n)
  );

  mbs_req_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst_n(srst_n), .phase_q(phase_q), .phase_n(phase_n),
    .ready(ready), .req_kind(req_kind), .req_wdata(req_wdata), .ad_i(ad_i),
    .cur_kind(cur_kind), .cur_wdata(cur_wdata), .rdata(rdata)
  );

  mbs_pin_drive #(.AW(AW), .DW(DW)) u_pins (
    .clk(clk), .rst_n(srst_n), .phase_q(phase_q), .phase_n(phase_n),
    .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
    .cur_kind(cur_kind), .cur_wdata(cur_wdata),
    .ale_q(ale), .ad_oe_q(ad_oe), .ad_q(ad_o), .a_hi_q(a_hi_o),
    .m_io_q(m_io), .dt_r_q(dt_r), .rd_n_q(rd_n), .wr_n_q(wr_n),
    .den_n_q(den_n), .sts_q(sts), .done_q(done), .acc_q(req_accept)
  );

endmodule

// File: tb/mux_bus_seq_tb_top.sv
module mux_bus_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  req_kind;
  logic [19:0] req_addr;
  logic [15:0] req_wdata;
  logic        req_accept;
  logic        ready;
  logic [15:0] ad_i;
  logic [15:0] ad_o;
  logic        ad_oe;
  logic [3:0]  a_hi_o;
  logic        ale, m_io, dt_r, rd_n, wr_n, den_n, done;
  logic [2:0]  sts;
  logic [15:0] rdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  mux_bus_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_accept(req_accept),
    .ready(ready), .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe), .a_hi_o(a_hi_o),
    .ale(ale), .m_io(m_io), .dt_r(dt_r), .rd_n(rd_n), .wr_n(wr_n),
    .den_n(den_n), .sts(sts), .done(done), .rdata(rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] pins_now();
    return {ale, ad_oe, m_io, dt_r, rd_n, wr_n, den_n, done, req_accept, sts};
  endfunction

  function automatic logic [11:0] pexp(input bit a, input bit oe, input bit mio,
      input bit dtr, input bit rdn, input bit wrn, input bit denn, input bit dn,
      input bit acc, input logic [2:0] s);
    return {a, oe, mio, dtr, rdn, wrn, denn, dn, acc, s};
  endfunction

  function automatic bit is_wr(input logic [2:0] k);  return k == 3'd2 || k == 3'd6; endfunction
  function automatic bit is_rd(input logic [2:0] k);  return k == 3'd1 || k == 3'd4 || k == 3'd5; endfunction
  function automatic bit is_rcv(input logic [2:0] k); return is_rd(k) || k == 3'd0; endfunction

  task automatic idle_check(input string tag);
    chk(tag, {20'd0, pins_now()}, {20'd0, pexp(0,0,0,0,1,1,1,0,0,3'b111)});
  endtask

  // Called at a falling edge; returns at the falling edge inside T4.
  task automatic do_cycle(input logic [2:0] k, input logic [19:0] a,
      input logic [15:0] wd, input int nw, input logic [15:0] bv,
      input bit chain, input logic [2:0] nk, input logic [19:0] na,
      input logic [15:0] nwd);
    bit w, r, h, m;
    w = is_wr(k); r = is_rd(k); h = (k == 3'd3); m = k[2];
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd;
    ready = 1'b0; ad_i = ~bv;
    @(negedge clk);
    chk("R2/R3/R5/R8 T1 pins", {20'd0, pins_now()},
        {20'd0, pexp(1,1,m,w,1,1,1,0,1,k)});
    chk("R2 T1 low address", {16'd0, ad_o}, {16'd0, a[15:0]});
    chk("R2 T1 high address", {28'd0, a_hi_o}, {28'd0, (m ? a[19:16] : 4'd0)});
    req_valid = 1'b0;
    @(negedge clk);
    chk("R4/R5/R6/R8/R11 T2 pins", {20'd0, pins_now()},
        {20'd0, pexp(0,w,m,w,!r,!w,h,0,0,k)});
    if (w) chk("R6 T2 write data", {16'd0, ad_o}, {16'd0, wd});
    for (int i = 0; i <= nw; i++) begin
      @(negedge clk);
      chk("R4/R7/R8/R11 T3-wait pins", {20'd0, pins_now()},
          {20'd0, pexp(0,w,m,w,!r,!w,h,0,0,3'b111)});
      if (w) chk("R6 late write data", {16'd0, ad_o}, {16'd0, wd});
      if (i == nw) begin
        ready = 1'b1; ad_i = bv;
        if (chain) begin
          req_valid = 1'b1; req_kind = nk; req_addr = na; req_wdata = nwd;
        end
      end
    end
    @(negedge clk);
    ready = 1'b0; ad_i = ~bv;
    chk("R3/R5/R7/R9 T4 pins", {20'd0, pins_now()},
        {20'd0, pexp(0,w,m,w,1,1,h,1,0,(chain ? nk : 3'b111))});
    if (w) chk("R6 T4 write data", {16'd0, ad_o}, {16'd0, wd});
    if (is_rcv(k)) chk("R10 read word", {16'd0, rdata}, {16'd0, bv});
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 3'd0; req_addr = '0;
    req_wdata = '0; ready = 1'b0; ad_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    idle_check("R1 after reset");
    chk("R10 reset read word", {16'd0, rdata}, 32'd0);

    // R11: READY toggling while idle changes nothing
    for (int i = 0; i < 4; i++) begin
      ready = ~ready;
      @(negedge clk);
      idle_check("R1/R11 idle with READY toggling");
    end
    ready = 1'b0;

    // sweep all kinds against 0..3 wait states
    for (int k = 0; k < 7; k++) begin
      for (int nw = 0; nw < 4; nw++) begin
        logic [19:0] a;
        logic [15:0] wd, bv;
        a  = 20'h81234 + 20'h13579 * k + 20'h00F0F * nw;
        wd = 16'h1000 * k + 16'h0101 * nw + 16'h002A;
        bv = ~wd ^ 16'h5A5A;
        do_cycle(3'(k), a, wd, nw, bv, 1'b0, 3'd0, 20'd0, 16'd0);
        @(negedge clk);
        idle_check("R1 idle between cycles");
        if (is_rcv(3'(k))) chk("R10 word held in idle", {16'd0, rdata}, {16'd0, bv});
      end
    end

    // R9: back-to-back cycles with status preview in T4
    do_cycle(3'd5, 20'hABCDE, 16'h0000, 1, 16'h3C3C, 1'b1, 3'd2, 20'h12345, 16'hBEEF);
    do_cycle(3'd2, 20'h12345, 16'hBEEF, 0, 16'h0000, 1'b1, 3'd4, 20'hF00D5, 16'h0000);
    do_cycle(3'd4, 20'hF00D5, 16'h0000, 2, 16'h7E81, 1'b0, 3'd0, 20'd0, 16'd0);
    chk("R10 word after chained cycles", {16'd0, rdata}, {16'd0, 16'h7E81});
    @(negedge clk);
    idle_check("R1 idle after chain");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R3 actual=hung expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule